// File: doc/BRIEF.md
# Stepped Soft-Start Current-Limit Sequencer

This block brings one regulator channel up gently. It waits for three qualifiers: the supply past its power-on threshold, the supply above the undervoltage-lockout level, and the channel enable. While any of them is low, switching is held off and the block stays idle. When all three are high, the block enables switching and raises the allowed current limit in five equal steps. It starts at one fifth of full scale and adds one fifth at the end of each phase of fixed length.

A phase lasts `PHASE_US` microseconds. A prescaler derives microsecond ticks from `CLK_HZ`, and a phase counter counts those ticks. The ramp ends in one of two ways. After the fifth phase expires, the limit stays at full scale. If the regulation-reached input asserts during the ramp, the block jumps to full scale at once. A registered done flag follows termination by one cycle. Comparators stay outside the block; only their digital results arrive here.

The controller has three named states. `SS_IDLE` means switching is off and the code is 0. `SS_RAMP` means switching is on and the code steps from 1 to 5. `SS_HOLD` means the ramp has ended and the code is held at 5. The transitions are:
- **start**: `SS_IDLE` to `SS_RAMP` when all qualifiers are high.
- **step**: `SS_RAMP` to `SS_RAMP` at each phase end while the code is below 5.
- **expire**: `SS_RAMP` to `SS_HOLD` at the end of phase five.
- **early**: `SS_RAMP` to `SS_HOLD` when regulation is reached.
- **abort**: any state to `SS_IDLE` when any qualifier drops.

Top module: `softstart_seq`

## Requirements
- R1: While `por_ok` is low, or in the cycle after it has been low, `ilim_code` is 0, `sw_en` is 0 and `ss_done` is 0. The asynchronous `rst_n` gives the same state.
- R2: `sw_en` is 0 in every cycle that follows a cycle with `uvlo_ok` low.
- R3: From idle, one clock edge with `por_ok`, `uvlo_ok` and `chan_en` all high yields `ilim_code` = 1 (20%) and `sw_en` = 1.
- R4: During the ramp, `ilim_code` rises by exactly 1 every P = (CLK_HZ/1,000,000)·PHASE_US cycles, with no other change.
- R5: With no regulation signal, the ramp ends 5·P cycles after it starts, and `ilim_code` is then held at 5 (100%).
- R6: `in_reg` high during the ramp makes `ilim_code` 5 at the next edge and ends the ramp.
- R7: `ss_done` rises exactly one cycle after the ramp ends. It stays high while the qualifiers stay high.
- R8: If any qualifier drops, the next edge clears `ilim_code`, `sw_en` and `ss_done`. A later start begins again at code 1.
- R9: `in_reg` has no effect in idle or after the ramp has ended.
- R10: `ilim_code` never exceeds 5, and `sw_en` is high exactly when `ilim_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on threshold; low clears the sequence |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| chan_en | input | 1 | Channel enable |
| in_reg | input | 1 | Output has reached regulation |
| ilim_code | output | 3 | Current-limit level, 0 = off, n = n·20% |
| sw_en | output | 1 | Switching enable |
| ss_done | output | 1 | Soft-start finished, registered |

## Verification
The bench builds the block with CLK_HZ = 3,000,000 and PHASE_US = 5. This gives a prescaler that divides by three and a phase of 15 cycles. A full five-phase ramp then takes 75 cycles instead of tens of thousands. Many complete ramps, early exits and aborts in every phase therefore fit within the run. The non-unity prescaler still exercises the wrap of the tick counter inside a phase.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_HOLD = 2'd2
    } ss_state_t;
endpackage

// File: rtl/ss_us_tick.sv
module ss_us_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = !clr;
        end else begin : g_div
            localparam int unsigned DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (clr)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = !clr && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ss_phase_timer.sv
module ss_phase_timer #(
    parameter int unsigned LEN = 425
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic phase_end
);
    generate
        if (LEN <= 1) begin : g_single
            assign phase_end = tick && !clr;
        end else begin : g_count
            localparam int unsigned PW = $clog2(LEN);
            localparam logic [PW-1:0] LAST = PW'(LEN - 1);
            logic [PW-1:0] ph_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ph_q <= '0;
                else if (clr)
                    ph_q <= '0;
                else if (tick) begin
                    if (ph_q == LAST)
                        ph_q <= '0;
                    else
                        ph_q <= ph_q + 1'b1;
                end
            end

            assign phase_end = tick && !clr && (ph_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PHASE_US   = 425,
    parameter int unsigned NUM_PHASES = 5,
    parameter int unsigned CODE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              uvlo_ok,
    input  logic              chan_en,
    input  logic              in_reg,
    output logic [CODE_W-1:0] ilim_code,
    output logic              sw_en,
    output logic              ss_done
);
    localparam int unsigned US_DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam logic [CODE_W-1:0] CODE_FULL  = CODE_W'(NUM_PHASES);
    localparam logic [CODE_W-1:0] CODE_FIRST = CODE_W'(1);

    ss_state_t         state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic              sw_q, done_q;
    logic              run_ok;
    logic              timer_clr;
    logic              us_tick;
    logic              phase_end;

    assign run_ok    = por_ok && uvlo_ok && chan_en;
    assign timer_clr = (state_q != SS_RAMP);

    ss_us_tick #(.DIV(US_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .tick  (us_tick)
    );

    ss_phase_timer #(.LEN(PHASE_US)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (timer_clr),
        .tick      (us_tick),
        .phase_end (phase_end)
    );

    // next-state and next-level decode
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            SS_IDLE: begin
                if (run_ok) begin
                    state_d = SS_RAMP;          // start
                    code_d  = CODE_FIRST;
                end
            end
            SS_RAMP: begin
                if (in_reg) begin
                    state_d = SS_HOLD;          // early
                    code_d  = CODE_FULL;
                end else if (phase_end) begin
                    if (code_q == CODE_FULL)
                        state_d = SS_HOLD;      // expire
                    else
                        code_d = code_q + 1'b1; // step
                end
            end
            SS_HOLD: begin
                code_d = CODE_FULL;
            end
            default: begin
                state_d = SS_IDLE;
                code_d  = '0;
            end
        endcase
        if (!run_ok) begin
            state_d = SS_IDLE;                  // abort
            code_d  = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SS_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            sw_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            code_q <= code_d;
            sw_q   <= (state_d != SS_IDLE);
            done_q <= (state_q == SS_HOLD) && run_ok;
        end
    end

    assign ilim_code = code_q;
    assign sw_en     = sw_q;
    assign ss_done   = done_q;
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned NUM_PHASES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_ok,
    input logic              uvlo_ok,
    input logic              chan_en,
    input logic              in_reg,
    input logic [CODE_W-1:0] ilim_code,
    input logic              sw_en,
    input logic              ss_done
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(NUM_PHASES);
    logic run;
    assign run = por_ok && uvlo_ok && chan_en;

    p_por_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (ilim_code == '0 && !sw_en && !ss_done));

    p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> !sw_en);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && run) |=> (ilim_code == CODE_W'(1) && sw_en));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && run && !in_reg && ilim_code != FULL)
        |=> (ilim_code == $past(ilim_code) || ilim_code == $past(ilim_code) + CODE_W'(1)));

    p_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && run && in_reg) |=> (ilim_code == FULL));

    p_done_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ilim_code == FULL && sw_en));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ilim_code == '0 && !sw_en && !ss_done));

    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_code <= FULL) && (sw_en == (ilim_code != '0)));
endmodule

bind softstart_seq ss_checker #(.CODE_W(CODE_W), .NUM_PHASES(NUM_PHASES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .uvlo_ok   (uvlo_ok),
    .chan_en   (chan_en),
    .in_reg    (in_reg),
    .ilim_code (ilim_code),
    .sw_en     (sw_en),
    .ss_done   (ss_done)
);

// File: tb/sim_softstart_seq.sv
`timescale 1ns/1ps
module sim_softstart_seq;
    localparam int unsigned CLK_HZ   = 3_000_000;
    localparam int unsigned PHASE_US = 5;
    localparam int P = (CLK_HZ / 1_000_000) * PHASE_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok = 1'b0, uvlo_ok = 1'b0, chan_en = 1'b0, in_reg = 1'b0;
    logic [2:0] ilim_code;
    logic sw_en, ss_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    softstart_seq #(.CLK_HZ(CLK_HZ), .PHASE_US(PHASE_US)) u0 (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .uvlo_ok(uvlo_ok),
        .chan_en(chan_en), .in_reg(in_reg),
        .ilim_code(ilim_code), .sw_en(sw_en), .ss_done(ss_done)
    );

    // reference model from the requirements
    int m_st = 0;
    int m_cnt = 0;
    logic [2:0] m_code = 3'd0;
    logic m_sw = 1'b0, m_done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_code = 3'd0; m_sw = 1'b0; m_done = 1'b0;
        end else begin
            logic run;
            run = por_ok && uvlo_ok && chan_en;
            m_done = (m_st == 2) && run;
            if (!run) begin
                m_st = 0; m_code = 3'd0; m_sw = 1'b0; m_cnt = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_code = 3'd1; m_sw = 1'b1; m_cnt = 0;
            end else if (m_st == 1) begin
                if (in_reg) begin
                    m_st = 2; m_code = 3'd5;
                end else if (m_cnt == P - 1) begin
                    m_cnt = 0;
                    if (m_code == 3'd5) m_st = 2;
                    else m_code = m_code + 3'd1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check("R4 model ilim_code", int'(ilim_code), int'(m_code));
        check("R2 model sw_en", int'(sw_en), int'(m_sw));
        check("R7 model ss_done", int'(ss_done), int'(m_done));
        check("R10 range", int'(ilim_code <= 3'd5 && sw_en == (ilim_code != 0)), 1);
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        report();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        wait_n(3);
        check("R1 reset code", int'(ilim_code), 0);
        check("R1 reset sw_en", int'(sw_en), 0);
        rst_n = 1'b1;
        por_ok = 1'b1; chan_en = 1'b1;
        wait_n(5);
        check("R2 lockout holds sw_en", int'(sw_en), 0);

        // full ramp
        uvlo_ok = 1'b1;
        wait_n(1);
        check("R3 start code", int'(ilim_code), 1);
        check("R3 start sw_en", int'(sw_en), 1);
        for (int k = 1; k <= 4; k++) begin
            wait_n(P - 1);
            check("R4 before step", int'(ilim_code), k);
            wait_n(1);
            check("R4 step", int'(ilim_code), k + 1);
        end
        wait_n(P);
        check("R5 held at full", int'(ilim_code), 5);
        check("R7 done not yet", int'(ss_done), 0);
        wait_n(1);
        check("R7 done one cycle later", int'(ss_done), 1);

        // regulation after end
        in_reg = 1'b1;
        wait_n(10);
        check("R9 in_reg after end", int'(ilim_code), 5);
        chan_en = 1'b0;
        wait_n(1);
        check("R8 abort code", int'(ilim_code), 0);
        check("R8 abort done", int'(ss_done), 0);
        wait_n(5);
        check("R9 in_reg in idle", int'(ilim_code), 0);
        in_reg = 1'b0;

        // early exit in phase 2
        chan_en = 1'b1;
        wait_n(1);
        check("R8 restart at 1", int'(ilim_code), 1);
        wait_n(P + 3);
        check("R4 phase two", int'(ilim_code), 2);
        in_reg = 1'b1;
        wait_n(1);
        check("R6 early jump", int'(ilim_code), 5);
        check("R7 done lags", int'(ss_done), 0);
        in_reg = 1'b0;
        wait_n(1);
        check("R7 done after early", int'(ss_done), 1);

        // power-on loss mid ramp
        chan_en = 1'b0; wait_n(1); chan_en = 1'b1;
        wait_n(2 * P + 4);
        por_ok = 1'b0;
        wait_n(1);
        check("R1 por clears code", int'(ilim_code), 0);
        check("R1 por clears sw_en", int'(sw_en), 0);
        por_ok = 1'b1;

        // random mix
        for (int i = 0; i < 6000; i++) begin
            por_ok  = ($urandom % 400) != 0;
            uvlo_ok = ($urandom % 300) != 0;
            chan_en = ($urandom % 250) != 0;
            in_reg  = ($urandom % 60) == 0;
            wait_n(1);
        end
        report();
    end
endmodule